// File: doc/BRIEF.md
# Programmable Modulo Interrupt Timer

A periodic interrupt source. A free-running prescaler divides the input clock by a programmable power of two, and each prescaled tick advances an up-counter. When the counter has reached a programmable modulo value, the next tick returns it to zero and raises a sticky overflow flag. When that flag is enabled, it drives a level-sensitive interrupt request. Software runs the timer through a small byte-wide register bus. One control/status byte holds the flag, the enable, a stop control, a counter-reset strobe and the prescaler select. Four more byte locations show the counter and hold the modulo value.

The flag can be cleared only by a two-step handshake. Software first reads the control/status byte while the flag is set, which arms the clear. It then writes a zero to the flag bit. If an overflow lands between those two steps, the arming is cancelled and the flag stays set. An overflow can therefore never be acknowledged without software seeing it.

Top module: `modulo_irq_timer`

## Requirements
- R1: After reset the control/status byte reads 0x20 (stopped, everything else clear), the counter reads 0, the modulo reads 0xFFFF and `irq` is low.
- R2: Writing the control/status byte with bit 4 set clears the counter and the prescaler on that edge, and no tick is taken in that cycle. Bits 4 and 3 always read back 0.
- R3: While the stop bit (bit 5) is 1, neither the counter nor the prescaler advances. Clearing it resumes counting from where it held.
- R4: With prescaler select N in bits 2:0, the counter advances once every 2^N enabled clocks (N = 0 to 7).
- R5: A tick that finds the counter equal to the modulo value loads 0 into the counter and sets the overflow flag (bit 7) on the same edge. Any other tick increments the counter.
- R6: The flag clears only when a write with bit 7 = 0 follows a read of the control/status byte made while the flag was 1. A write of 0 without such a read, and any write of 1, leave the flag as it was.
- R7: An overflow that occurs after the arming read cancels the arming. The following write of 0 then leaves the flag set.
- R8: `irq` is high exactly when the flag and the enable (bit 6) are both 1, and it stays high while both are.
- R9: Address map: 0 is control/status, 1 and 2 are counter high/low (read-only, so writes are ignored), 3 and 4 are modulo high/low. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for `addr` |
| rd_en | input | 1 | Read strobe for `addr` (arms the flag clear) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A small modulo with divide-by-one makes overflows dense. The read-to-write gap is then swept from zero to six cycles, so some handshakes complete and others are overtaken by an overflow. This separates a correct cancel from a flag that clears unconditionally. Divide ratios of 4 and 128 show that the prescaler select sets the tick spacing. Stopping mid-count and then resuming shows that both the counter and the prescaler hold their state. A run with the enable low shows the flag setting while the interrupt stays quiet. Writes of 0 without a prior read, and writes of 1, show that neither clears the flag on its own.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    localparam int ADDR_W = 3;
    localparam int DATA_W = 8;
    localparam int PS_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_CNT_HI = 3'd1,
        A_CNT_LO = 3'd2,
        A_MOD_HI = 3'd3,
        A_MOD_LO = 3'd4
    } reg_addr_e;

    localparam int B_FLAG = 7;
    localparam int B_IE   = 6;
    localparam int B_STOP = 5;
    localparam int B_CRST = 4;

    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;
endpackage

// File: rtl/pmt_prescaler.sv
module pmt_prescaler #(
    parameter int PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            clear,
    input  logic [PS_W-1:0] sel,
    output logic            tick
);
    localparam int DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pre_d, pre_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask  = ~({DIV_W{1'b1}} << sel);
        tick  = run && !clear && ((pre_q & mask) == mask);
        pre_d = pre_q;
        if (clear)
            pre_d = '0;
        else if (run)
            pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/pmt_counter.sv
module pmt_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         clear,
    input  logic [W-1:0] modv,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        ovf   = 1'b0;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (tick) begin
            if (cnt_q == modv) begin
                cnt_d = '0;
                ovf   = 1'b1;
            end else begin
                cnt_d = cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pmt_flag.sv
module pmt_flag
    import pmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic rd_ctrl,
    input  logic wr_ctrl,
    input  logic wr_flag_bit,
    output logic flag,
    output logic armed
);
    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ovf) begin
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (wr_ctrl) begin
            if (st_q.armed && !wr_flag_bit)
                st_d.flag = 1'b0;
            st_d.armed = 1'b0;
        end else if (rd_ctrl && st_q.flag) begin
            st_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag  = st_q.flag;
    assign armed = st_q.armed;
endmodule

// File: rtl/modulo_irq_timer.sv
module modulo_irq_timer
    import pmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int EXT_W = 2 * DATA_W;

    typedef struct packed {
        logic             ie;
        logic             stop;
        logic [PS_W-1:0]  ps;
        logic [CNT_W-1:0] modv;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             wr_ctrl, rd_ctrl, cnt_clr, tick, ovf_evt, flag, armed;
    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] cnt_ext, mod_ext;

    always_comb begin
        wr_ctrl = wr_en && (addr == A_CTRL);
        rd_ctrl = rd_en && (addr == A_CTRL);
        cnt_clr = wr_ctrl && wdata[B_CRST];
        r_d     = r_q;
        if (wr_ctrl) begin
            r_d.ie   = wdata[B_IE];
            r_d.stop = wdata[B_STOP];
            r_d.ps   = wdata[PS_W-1:0];
        end
        mod_ext = EXT_W'(r_q.modv);
        if (wr_en && addr == A_MOD_HI)
            r_d.modv = CNT_W'({wdata, mod_ext[DATA_W-1:0]});
        if (wr_en && addr == A_MOD_LO)
            r_d.modv = CNT_W'({mod_ext[EXT_W-1:DATA_W], wdata});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.ie   <= 1'b0;
            r_q.stop <= 1'b1;
            r_q.ps   <= '0;
            r_q.modv <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    pmt_prescaler #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(!r_q.stop), .clear(cnt_clr),
        .sel(r_q.ps), .tick(tick)
    );

    pmt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .clear(cnt_clr),
        .modv(r_q.modv), .cnt(cnt), .ovf(ovf_evt)
    );

    pmt_flag u_flag (
        .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .rd_ctrl(rd_ctrl),
        .wr_ctrl(wr_ctrl), .wr_flag_bit(wdata[B_FLAG]),
        .flag(flag), .armed(armed)
    );

    always_comb begin
        cnt_ext = EXT_W'(cnt);
        unique case (addr)
            A_CTRL:   rdata = {flag, r_q.ie, r_q.stop, 2'b00, r_q.ps};
            A_CNT_HI: rdata = cnt_ext[EXT_W-1:DATA_W];
            A_CNT_LO: rdata = cnt_ext[DATA_W-1:0];
            A_MOD_HI: rdata = mod_ext[EXT_W-1:DATA_W];
            A_MOD_LO: rdata = mod_ext[DATA_W-1:0];
            default:  rdata = '0;
        endcase
        irq = flag && r_q.ie;
    end
endmodule

// File: rtl/pmt_checker.sv
module pmt_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         ovf,
    input logic         flag,
    input logic         armed,
    input logic         stop,
    input logic         ie,
    input logic         irq,
    input logic         cnt_clr,
    input logic [W-1:0] cnt
);
    assert_stop_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !cnt_clr) |=> $stable(cnt));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);

    assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == '0));

    assert_no_clear_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !armed) |=> flag);

    assert_cancel_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> !armed);

    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);
endmodule

bind modulo_irq_timer pmt_checker #(.W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ovf(ovf_evt), .flag(flag), .armed(armed),
    .stop(r_q.stop), .ie(r_q.ie), .irq(irq), .cnt_clr(cnt_clr), .cnt(cnt)
);

// File: tb/test_modulo_irq_timer.sv
module test_modulo_irq_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int    checks = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // reference model state
    int m_flag, m_armed, m_ie, m_stop, m_ps, m_cnt, m_mod, m_pre;

    always #(CLK_PERIOD/2) clk = ~clk;

    modulo_irq_timer i_modulo_irq_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always @(posedge clk) begin
        bit wctl;
        bit ov;
        if (!rst_n) begin
            m_flag = 0; m_armed = 0; m_ie = 0; m_stop = 1; m_ps = 0;
            m_cnt = 0; m_mod = 16'hFFFF; m_pre = 0;
        end else begin
            wctl = wr_en && addr == 3'd0;
            ov   = 1'b0;
            if (wctl && wdata[4]) begin
                m_cnt = 0; m_pre = 0;
            end else if (m_stop == 0) begin
                if (m_pre == (1 << m_ps) - 1) begin
                    m_pre = 0;
                    if (m_cnt == m_mod) begin m_cnt = 0; ov = 1'b1; end
                    else m_cnt = (m_cnt + 1) & 16'hFFFF;
                end else begin
                    m_pre = m_pre + 1;
                end
            end
            if (ov) begin
                m_flag = 1; m_armed = 0;
            end else if (wctl) begin
                if (m_armed == 1 && wdata[7] == 1'b0) m_flag = 0;
                m_armed = 0;
            end else if (rd_en && addr == 3'd0 && m_flag == 1) begin
                m_armed = 1;
            end
            if (wctl) begin
                m_ie = wdata[6]; m_stop = wdata[5]; m_ps = wdata[2:0];
            end
            if (wr_en && addr == 3'd3) m_mod = (m_mod & 8'hFF) | (wdata << 8);
            if (wr_en && addr == 3'd4) m_mod = (m_mod & 16'hFF00) | wdata;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return 8'((m_flag << 7) | (m_ie << 6) | (m_stop << 5) | m_ps);
            3'd1: return 8'(m_cnt >> 8);
            3'd2: return 8'(m_cnt);
            3'd3: return 8'(m_mod >> 8);
            3'd4: return 8'(m_mod);
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare();
        logic [7:0] e;
        logic       ei;
        e  = exp_rd(addr);
        ei = (m_flag == 1 && m_ie == 1);
        checks++;
        if (rdata !== e) begin
            fails++;
            $display("FAIL %s rdata addr %0d got %02h expected %02h", cur_req, addr, rdata, e);
        end
        checks++;
        if (irq !== ei) begin
            fails++;
            $display("FAIL R8 irq got %b expected %b", irq, ei);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic watch(input logic [2:0] a, input int n);
        addr = a;
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a; rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        cur_req = "R1";
        for (int a = 0; a < 5; a++) watch(3'(a), 1);
        // R9: unmapped reads and counter writes ignored
        cur_req = "R9";
        watch(3'd5, 1); watch(3'd7, 1);
        wr(3'd2, 8'h55); watch(3'd2, 2);
        wr(3'd3, 8'h00); wr(3'd4, 8'h03); watch(3'd4, 1);
        // R5: run with divide-by-one, modulo 3
        cur_req = "R5";
        wr(3'd0, 8'h50);
        watch(3'd2, 12); watch(3'd0, 4);
        // R6: write 0 without a read, and write 1
        cur_req = "R6";
        wr(3'd0, 8'h40); watch(3'd0, 2);
        wr(3'd0, 8'hC0); watch(3'd0, 2);
        // R7: sweep read-to-write gap against dense overflows
        cur_req = "R7";
        for (int d = 0; d < 7; d++) begin
            rd(3'd0);
            watch(3'd0, d);
            wr(3'd0, 8'h40);
            watch(3'd0, 2);
        end
        // R6: clean clear while stopped
        cur_req = "R6";
        wr(3'd0, 8'h60); watch(3'd0, 1);
        rd(3'd0); wr(3'd0, 8'h60); watch(3'd0, 3);
        // R8: enable low, flag still sets
        cur_req = "R8";
        wr(3'd0, 8'h10); watch(3'd0, 10);
        wr(3'd0, 8'h40); watch(3'd0, 3);
        // R4: divide by 4 and by 128
        cur_req = "R4";
        wr(3'd0, 8'h52); wr(3'd4, 8'h02);
        watch(3'd2, 40);
        wr(3'd0, 8'h57); watch(3'd2, 300);
        // R3: stop mid-count and resume
        cur_req = "R3";
        wr(3'd0, 8'h52); watch(3'd2, 6);
        wr(3'd0, 8'h72); watch(3'd2, 10);
        wr(3'd0, 8'h52); watch(3'd2, 10);
        // R2: counter reset with bit 3 set, both read 0
        cur_req = "R2";
        watch(3'd2, 1);
        wr(3'd0, 8'h5A); watch(3'd0, 2);
        wr(3'd0, 8'h70); watch(3'd2, 3);
        finish_run();
    end
endmodule